// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block evaluates a set of Boolean functions in sum-of-products form over a small group of binary inputs. A row of product terms samples the input literals (each variable in true and complemented form) and ANDs together those it is connected to. A row of output sums then ORs together the product terms each output is connected to. Both connection sets live in registers loaded through a simple address/data/write-enable port. The outputs follow the inputs combinationally once the connections are loaded.

A stored mode code sets which of the two connection sets is honoured. In decoder mode the AND side is a fixed full minterm decoder and only the output sums are programmable. In grouped mode the product terms are programmable and each output sums a fixed, contiguous block of terms. In free mode both sides are programmable, so one product term can be generated once and shared by several outputs. Parameters are the input count `N`, the term count `P` and the output count `M`. Decoder mode needs `P >= 2**N`.

Top module: `sop_logic_array`

## Requirements
- R1: After synchronous reset every connection is cleared, the mode code is free mode (2), and every output reads 0 for every input value.
- R2: A write with `cfg_we` high at a rising edge stores `cfg_wdata` and takes effect from that edge on, and not before it. AND row k is at address k, with bit 2i selecting input i true and bit 2i+1 selecting input i complemented. Output row j is at address P+j, with bit k selecting term k. The mode code is at address P+M.
- R3: A product term with no literal selected evaluates to 0 outside decoder mode, so unused terms never drive an output high.
- R4: In free mode (code 2), output j is the OR of every term k whose bit k is set in output row j. Each term is the AND of its selected literals.
- R5: In free mode a single product term routed to several output rows contributes to each of those outputs.
- R6: In decoder mode (code 0), term k for k < 2**N is 1 exactly when the input value equals k, and the stored AND rows have no effect. Output j is the OR of the terms its row selects.
- R7: In grouped mode (code 1), output j is the OR of terms j*(P/M) through (j+1)*(P/M)-1, and the output rows have no effect.
- R8: Writes to output rows while in grouped mode are discarded. The previous row contents still apply after returning to free mode.
- R9: Writing the reserved mode code 3 leaves the current mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | $clog2(P+M+1) | Configuration row or mode address |
| cfg_wdata | input | max(2N,P) | Configuration write data |
| in_vec | input | N | Binary input variables, bit i is variable i |
| out_vec | output | M | Sum-of-products outputs |

## Verification
Every register feeds the outputs combinationally, so a wrong stored bit shows up at `out_vec` in the same cycle as the first input value that depends on it. A corrupted mode code, a lost or leaked output-row write, or a term that fires with no literals therefore appears during the first full sweep of the eight input values after that write. The test programs one pair of functions, with one shared product term, into each mode and compares every input combination against formulas evaluated in the bench. It also checks write latency right before and right after the edge.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

    typedef enum logic [1:0] {
        MODE_PROM = 2'd0,
        MODE_PAL  = 2'd1,
        MODE_PLA  = 2'd2
    } arr_mode_e;

    localparam logic [1:0] MODE_RESERVED = 2'd3;

    function automatic logic mode_code_ok(input logic [1:0] code);
        return code != MODE_RESERVED;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
    import sop_array_pkg::*;
#(
    parameter int N  = 3,
    parameter int P  = 8,
    parameter int M  = 2,
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    output logic [P-1:0][2*N-1:0]      and_mask,
    output logic [M-1:0][P-1:0]        or_mask,
    output arr_mode_e                  mode_q
);
    localparam logic [AW-1:0] MODE_ADDR = AW'(P + M);

    for (genvar r = 0; r < P; r++) begin : g_and_row
        always_ff @(posedge clk) begin
            if (rst)
                and_mask[r] <= '0;
            else if (we && addr == AW'(r))
                and_mask[r] <= wdata[2*N-1:0];
        end
    end

    for (genvar j = 0; j < M; j++) begin : g_or_row
        always_ff @(posedge clk) begin
            if (rst)
                or_mask[j] <= '0;
            else if (we && addr == AW'(P + j) && mode_q != MODE_PAL)
                or_mask[j] <= wdata[P-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_PLA;
        else if (we && addr == MODE_ADDR && mode_code_ok(wdata[1:0]))
            mode_q <= arr_mode_e'(wdata[1:0]);
    end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_array_pkg::*;
#(
    parameter int N = 3,
    parameter int P = 8
) (
    input  logic [N-1:0]               in_vec,
    input  logic [P-1:0][2*N-1:0]      and_mask,
    input  arr_mode_e                  mode,
    output logic [P-1:0]               term_vec
);
    localparam int LITS = 2 * N;
    localparam int MINTERMS = 2 ** N;

    logic [LITS-1:0] lit;

    for (genvar i = 0; i < N; i++) begin : g_lit
        assign lit[2*i]   = in_vec[i];
        assign lit[2*i+1] = ~in_vec[i];
    end

    for (genvar k = 0; k < P; k++) begin : g_term
        logic prog_term;
        logic dec_term;

        // a term with no connections is forced low
        assign prog_term = (|and_mask[k]) && (&(lit | ~and_mask[k]));

        if (k < MINTERMS) begin : g_dec
            assign dec_term = (in_vec == N'(k));
        end else begin : g_nodec
            assign dec_term = 1'b0;
        end

        assign term_vec[k] = (mode == MODE_PROM) ? dec_term : prog_term;
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_array_pkg::*;
#(
    parameter int P = 8,
    parameter int M = 2
) (
    input  logic [P-1:0]               term_vec,
    input  logic [M-1:0][P-1:0]        or_mask,
    input  arr_mode_e                  mode,
    output logic [M-1:0]               out_vec
);
    localparam int GROUP = P / M;

    for (genvar j = 0; j < M; j++) begin : g_out
        logic [P-1:0] fixed_sel;
        logic [P-1:0] sel;

        for (genvar k = 0; k < P; k++) begin : g_fix
            assign fixed_sel[k] = ((k / GROUP) == j);
        end

        assign sel        = (mode == MODE_PAL) ? fixed_sel : or_mask[j];
        assign out_vec[j] = |(term_vec & sel);
    end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
    import sop_array_pkg::*;
#(
    parameter int N = 3,
    parameter int P = 8,
    parameter int M = 2,
    localparam int AW = $clog2(P + M + 1),
    localparam int DW = int'(max_of(2 * N, P))
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic [N-1:0]    in_vec,
    output logic [M-1:0]    out_vec
);
    logic [P-1:0][2*N-1:0] and_mask_w;
    logic [M-1:0][P-1:0]   or_mask_w;
    arr_mode_e             mode_w;
    logic [P-1:0]          term_w;

    sop_cfg_store #(.N(N), .P(P), .M(M), .AW(AW), .DW(DW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .and_mask (and_mask_w),
        .or_mask  (or_mask_w),
        .mode_q   (mode_w)
    );

    sop_and_plane #(.N(N), .P(P)) u_and (
        .in_vec   (in_vec),
        .and_mask (and_mask_w),
        .mode     (mode_w),
        .term_vec (term_w)
    );

    sop_or_plane #(.P(P), .M(M)) u_or (
        .term_vec (term_w),
        .or_mask  (or_mask_w),
        .mode     (mode_w),
        .out_vec  (out_vec)
    );

endmodule

// File: rtl/sop_logic_array_chk.sv
module sop_logic_array_chk #(
    parameter int N  = 3,
    parameter int P  = 8,
    parameter int M  = 2,
    parameter int AW = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_we,
    input logic [AW-1:0]          cfg_addr,
    input logic [1:0]             mode_code,
    input logic [1:0]             mode_q,
    input logic [P-1:0][2*N-1:0]  and_mask,
    input logic [M-1:0][P-1:0]    or_mask,
    input logic [P-1:0]           term_vec,
    input logic [M-1:0]           out_vec
);
    localparam logic [AW-1:0] MODE_ADDR = AW'(P + M);
    localparam logic [AW-1:0] OR_LO     = AW'(P);

    AST_PAL_OR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr >= OR_LO && cfg_addr < MODE_ADDR && mode_q == 2'd1)
        |=> $stable(or_mask)); // R8

    AST_MODE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we || cfg_addr != MODE_ADDR) |=> $stable(mode_q)); // R2

    AST_RESERVED_MODE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == MODE_ADDR && mode_code == 2'd3) |=> $stable(mode_q)); // R9

    AST_DECODER_ONE_TERM: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd0) |-> ($countones(term_vec) == 1)); // R6

    AST_OUT_NEEDS_TERM: assert property (@(posedge clk) disable iff (rst)
        (|out_vec) |-> (|term_vec)); // R4

    for (genvar k = 0; k < P; k++) begin : g_empty
        AST_EMPTY_TERM_LOW: assert property (@(posedge clk) disable iff (rst)
            (mode_q != 2'd0 && and_mask[k] == '0) |-> !term_vec[k]); // R3
    end

endmodule

bind sop_logic_array sop_logic_array_chk #(.N(N), .P(P), .M(M), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .mode_code (cfg_wdata[1:0]),
    .mode_q    (mode_w),
    .and_mask  (and_mask_w),
    .or_mask   (or_mask_w),
    .term_vec  (term_w),
    .out_vec   (out_vec)
);

// File: tb/sop_logic_array_tb.sv
module sop_logic_array_tb_top;
    localparam int N = 3;
    localparam int P = 8;
    localparam int M = 2;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam logic [AW-1:0] MODE_A = 4'd10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [N-1:0]  in_vec = '0;
    logic [M-1:0]  out_vec;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sop_logic_array #(.N(N), .P(P), .M(M)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_vec(in_vec), .out_vec(out_vec)
    );

    // X = in[2], Y = in[1], Z = in[0]
    function automatic logic ref_a(input logic [2:0] v);
        return (v[2] & v[1]) | (v[2] & ~v[0]);
    endfunction
    function automatic logic ref_b(input logic [2:0] v);
        return (v[2] & ~v[1]) | (v[1] & v[0]) | (v[2] & ~v[0]);
    endfunction

    task automatic check_out(input logic [M-1:0] exp, input string tag);
        checks++;
        if (out_vec !== exp) begin
            errors++;
            $display("FAIL %s in=%0d actual=%b expected=%b", tag, in_vec, out_vec, exp);
        end
    endtask

    task automatic write_cfg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sweep(input bit b_zero, input string tag);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            in_vec = 3'(v);
            #1;
            check_out({b_zero ? 1'b0 : ref_b(3'(v)), ref_a(3'(v))}, tag);
        end
    endtask

    task automatic t_reset();
        do_reset();
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            in_vec = 3'(v);
            #1;
            check_out(2'b00, "R1 reset outputs");
        end
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_vec = 3'd4;
        write_cfg(4'd0, 8'h10);           // term0 = X
        #1;
        check_out(2'b00, "R2 no output row yet");
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 8'h01;
        #1;
        check_out(2'b00, "R2 before edge");
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check_out(2'b01, "R2 after edge");
        write_cfg(4'd9, 8'h01);
        #1;
        check_out(2'b11, "R1 default free mode");
        in_vec = 3'd3;
        #1;
        check_out(2'b00, "R4 literal false");
    endtask

    task automatic t_empty();
        do_reset();
        write_cfg(4'd8, 8'hFF);
        write_cfg(4'd9, 8'hFF);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            in_vec = 3'(v);
            #1;
            check_out(2'b00, "R3 empty terms low");
        end
    endtask

    task automatic prog_pla();
        write_cfg(MODE_A, 8'd2);
        write_cfg(4'd0, 8'h14);  // XY
        write_cfg(4'd1, 8'h12);  // XZ' shared
        write_cfg(4'd2, 8'h18);  // XY'
        write_cfg(4'd3, 8'h05);  // YZ
        for (int r = 4; r < 8; r++) write_cfg(4'(r), 8'h00);
        write_cfg(4'd8, 8'h03);
        write_cfg(4'd9, 8'h0E);
    endtask

    task automatic t_pla();
        prog_pla();
        sweep(1'b0, "R4 R5 free mode shared term");
    endtask

    task automatic t_pal_lock();
        write_cfg(MODE_A, 8'd1);
        write_cfg(4'd8, 8'hFF);
        write_cfg(MODE_A, 8'd2);
        sweep(1'b0, "R8 row write in grouped mode dropped");
    endtask

    task automatic t_pal();
        write_cfg(MODE_A, 8'd1);
        write_cfg(4'd0, 8'h14);
        write_cfg(4'd1, 8'h12);
        write_cfg(4'd2, 8'h00);
        write_cfg(4'd3, 8'h00);
        write_cfg(4'd4, 8'h18);
        write_cfg(4'd5, 8'h05);
        write_cfg(4'd6, 8'h12);
        write_cfg(4'd7, 8'h00);
        sweep(1'b0, "R7 grouped mode");
    endtask

    task automatic t_prom();
        logic [7:0] ma;
        logic [7:0] mb;
        for (int v = 0; v < 8; v++) begin
            ma[v] = ref_a(3'(v));
            mb[v] = ref_b(3'(v));
        end
        write_cfg(MODE_A, 8'd0);
        write_cfg(4'd8, ma);
        write_cfg(4'd9, mb);
        sweep(1'b0, "R6 decoder mode");
    endtask

    task automatic t_badmode();
        write_cfg(MODE_A, 8'd3);
        sweep(1'b0, "R9 reserved code ignored");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_empty();
        t_pla();
        t_pal_lock();
        t_pal();
        t_prom();
        t_badmode();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule